// File: doc/BRIEF.md
# Parallel Bus Read Target

This block is a slave on a shared, multiplexed address/data bus, and it serves reads only. An initiator opens a transaction by pulling the active-low framing input low. In that address-phase cycle the block captures the address and command from the shared lines. If the address falls inside a configurable power-of-two window and the command is a read, the block claims the transaction with an active-low select. The select comes one or two cycles after the address phase, and a parameter picks which.

The cycle after the address phase is a turnaround cycle, and the block drives no data in it. From the next cycle on, the block drives data words it fetches through a simple local read port. A request pulse carries a word index, and a valid strobe later returns the word. The block's active-low ready output paces each beat against the initiator's ready input. The block inserts wait states while a word is still being fetched. It holds a presented word until the initiator takes it.

The block treats a completed beat with framing high as the last beat. It then drives its control lines high for one cycle and releases every shared line. Drive on the shared lines is shown by output-enable signals.

Top module: `bus_read_target`

## Requirements
- R1: The block decodes only on a high-to-low change of `start_n` while it is idle. It claims the transaction when all three of these hold in that cycle: `ad_in[31:SIZE_LOG2]` equals the same bits of `BASE_ADDR`, `ad_in[1:0]` is 00, and `cmd_in` is the read code 4'h6. In the following cycle it pulses `rd_req` with `rd_addr = ad_in[SIZE_LOG2-1:2]`.
- R2: `sel_n` goes low in the first cycle after the address phase when `FAST_SEL` is 1, and in the second cycle when it is 0. It stays low in every data cycle.
- R3: In the turnaround cycle after the address phase, `tgt_rdy_n` is high and `ad_oe` is low, while `ctl_oe` is high.
- R4: From the second cycle after the address phase until the last beat, `ad_oe` is high. Whenever `tgt_rdy_n` is low, `ad_out` carries the word returned for the current index. A beat completes at a clock edge where `tgt_rdy_n` and `init_rdy_n` are both low.
- R5: `tgt_rdy_n` is low exactly from the cycle after `rd_valid` is sampled high until the beat completes, and high otherwise (target wait states).
- R6: While `tgt_rdy_n` is low and `init_rdy_n` is high, the next cycle keeps `tgt_rdy_n` low with `ad_out` unchanged.
- R7: After every completed beat that is not the last, `rd_req` pulses in the next cycle with `rd_addr` one greater, wrapping modulo 2^(SIZE_LOG2-2).
- R8: After a beat that completes with `start_n` high, the next cycle has `ctl_oe` high, `sel_n` and `tgt_rdy_n` high, and `ad_oe` low. In the cycle after that, `ctl_oe` is low.
- R9: A transaction that misses the window, has nonzero `ad_in[1:0]`, or carries any command other than 4'h6 never raises `ad_oe`, `ctl_oe` or `rd_req`.
- R10: While `start_n` stays low after a missed address phase, later values on `ad_in`/`cmd_in` start no decode, even if they would match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| start_n | input | 1 | Active-low transaction framing from the initiator |
| ad_in | input | 32 | Shared address/data lines as seen by the block |
| cmd_in | input | 4 | Command in the address phase, byte enables afterwards |
| init_rdy_n | input | 1 | Active-low initiator ready |
| ad_out | output | 32 | Data the block drives onto the shared lines |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| tgt_rdy_n | output | 1 | Active-low target ready |
| sel_n | output | 1 | Active-low claim of the transaction |
| ctl_oe | output | 1 | Drive enable for `tgt_rdy_n` and `sel_n` |
| rd_req | output | 1 | Local read request pulse |
| rd_addr | output | SIZE_LOG2-2 | Word index within the window |
| rd_valid | input | 1 | Local read data valid strobe |
| rd_data | input | 32 | Local read data word |

## Verification
The hardest case to reach is an initiator stall that lands exactly on a beat the block is presenting. The case is harder still when that beat is the final one, or the one whose index wraps at the top of the window, because the hold, the release and the index step must then line up. The bench sweeps every combination of local fetch latency 0 to 3, burst length 1 to 4 and four initiator stall patterns, from start offsets at the window's base, in its middle and two words below its top. It predicts each cycle's ready level from the latency and the previous beat. Two instances with opposite select timing share the bus so that both claim variants are compared cycle by cycle.

// File: rtl/bus_read_target.sv
module bus_read_target #(
  parameter int DW = 32,
  parameter logic [DW-1:0] BASE_ADDR = 32'h0000_1000,
  parameter int SIZE_LOG2 = 8,
  parameter logic [3:0] READ_CODE = 4'h6,
  parameter bit FAST_SEL = 1'b1,
  localparam int IW = SIZE_LOG2 - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_n,
  input  logic [DW-1:0] ad_in,
  input  logic [3:0]    cmd_in,
  input  logic          init_rdy_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          tgt_rdy_n,
  output logic          sel_n,
  output logic          ctl_oe,
  output logic          rd_req,
  output logic [IW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data
);

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_DATA, S_LAST} st_t;

  st_t           st;
  logic          start_q;
  logic          have;
  logic          req_q;
  logic [DW-1:0] word_q;
  logic [IW-1:0] idx_q;

  wire addr_edge = (st == S_IDLE) && start_q && !start_n;
  wire hit = (ad_in[DW-1:SIZE_LOG2] == BASE_ADDR[DW-1:SIZE_LOG2]) &&
             (ad_in[1:0] == 2'b00) && (cmd_in == READ_CODE);
  wire beat = (st == S_DATA) && have && !init_rdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      start_q <= 1'b1;
      have    <= 1'b0;
      req_q   <= 1'b0;
      word_q  <= '0;
      idx_q   <= '0;
    end else begin
      start_q <= start_n;
      req_q   <= 1'b0;
      if (rd_valid && (st == S_TURN || st == S_DATA)) begin
        have   <= 1'b1;
        word_q <= rd_data;
      end
      case (st)
        S_IDLE: if (addr_edge && hit) begin
          st    <= S_TURN;
          idx_q <= ad_in[SIZE_LOG2-1:2];
          req_q <= 1'b1;
          have  <= 1'b0;
        end
        S_TURN: st <= S_DATA;
        S_DATA: if (beat) begin
          have <= 1'b0;
          if (start_n) st <= S_LAST;
          else begin
            idx_q <= idx_q + 1'b1;
            req_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rd_req    = req_q;
  assign rd_addr   = idx_q;
  assign ad_out    = word_q;
  assign ad_oe     = (st == S_DATA);
  assign ctl_oe    = (st != S_IDLE);
  assign sel_n     = !((st == S_DATA) || (FAST_SEL && st == S_TURN));
  assign tgt_rdy_n = !((st == S_DATA) && have);

  assert_turn_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_edge && hit) |=> (tgt_rdy_n && !ad_oe && ctl_oe && rd_req));

  assert_sel_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_edge && hit) |=> (sel_n == !FAST_SEL));

  assert_sel_in_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!sel_n && ctl_oe));

  assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_rdy_n && init_rdy_n) |=> (!tgt_rdy_n && $stable(ad_out)));

  assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !start_n) |=> (rd_req && rd_addr == $past(rd_addr) + 1'b1));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && start_n) |=> (ctl_oe && sel_n && tgt_rdy_n && !ad_oe) ##1 !ctl_oe);

  assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_edge && !hit) |=> (!ctl_oe && !ad_oe && !rd_req));

  assert_no_redecode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_oe && !start_n && !start_q) |=> !ctl_oe);

endmodule

// File: tb/bus_read_target_tb.sv
`timescale 1ns/1ps
module bus_read_target_tb_top;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1;
  logic [31:0] ad_in = '0;
  logic [3:0] cmd_in = '0;
  logic init_rdy_n = 1'b1;
  logic rd_valid = 1'b0;
  logic [31:0] rd_data = '0;

  logic [31:0] ad_out_i, ad_out_m;
  logic ad_oe_i, ad_oe_m, tgt_n_i, tgt_n_m, sel_n_i, sel_n_m, ctl_oe_i, ctl_oe_m;
  logic rd_req_i, rd_req_m;
  logic [5:0] rd_addr_i, rd_addr_m;

  int nchk = 0;
  int nfail = 0;
  int lat_g = 0;

  always #2 clk = ~clk;

  bus_read_target #(.BASE_ADDR(BASE), .FAST_SEL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .ad_in(ad_in), .cmd_in(cmd_in),
    .init_rdy_n(init_rdy_n), .ad_out(ad_out_i), .ad_oe(ad_oe_i), .tgt_rdy_n(tgt_n_i),
    .sel_n(sel_n_i), .ctl_oe(ctl_oe_i), .rd_req(rd_req_i), .rd_addr(rd_addr_i),
    .rd_valid(rd_valid), .rd_data(rd_data));

  bus_read_target #(.BASE_ADDR(BASE), .FAST_SEL(1'b0)) dut_m (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .ad_in(ad_in), .cmd_in(cmd_in),
    .init_rdy_n(init_rdy_n), .ad_out(ad_out_m), .ad_oe(ad_oe_m), .tgt_rdy_n(tgt_n_m),
    .sel_n(sel_n_m), .ctl_oe(ctl_oe_m), .rd_req(rd_req_m), .rd_addr(rd_addr_m),
    .rd_valid(rd_valid), .rd_data(rd_data));

  function automatic logic [31:0] word_of(int a);
    return 32'hC0DE_0000 + 32'(a % 64) * 32'h0000_0101;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  bit mpend = 0;
  int mcnt = 0;
  logic [5:0] maddr = '0;
  always @(negedge clk) begin
    logic v;
    v = 1'b0;
    if (rd_req_i) begin mpend = 1; mcnt = lat_g; maddr = rd_addr_i; end
    if (mpend) begin
      if (mcnt == 0) begin v = 1'b1; mpend = 0; end
      else mcnt--;
    end
    rd_valid <= v;
    rd_data  <= word_of(int'(maddr));
  end

  task automatic run_read(int off, int nb, int lat, int pat);
    int k, done, ready;
    bit last, irdy, stall;
    logic [31:0] held;
    lat_g = lat;
    @(negedge clk);
    start_n = 1'b0; ad_in = BASE + 32'(off * 4); cmd_in = 4'h6; init_rdy_n = 1'b1;
    @(negedge clk);
    chk("R3 turnaround ready", 32'(tgt_n_i), 1);
    chk("R3 turnaround ad_oe", 32'(ad_oe_i), 0);
    chk("R3 turnaround ctl_oe", 32'(ctl_oe_m), 1);
    chk("R2 fast select", 32'(sel_n_i), 0);
    chk("R2 medium select", 32'(sel_n_m), 1);
    k = 0; done = 0; ready = lat + 1; last = 0; stall = 0; held = '0;
    while (done < nb && k < 80) begin
      if (k == ready - lat - 1) begin
        chk(k == 0 ? "R1 first request" : "R7 next request", 32'(rd_req_i), 1);
        chk(k == 0 ? "R1 word index" : "R7 word index", 32'(rd_addr_i), 32'((off + done) % 64));
      end
      if (k > 0) begin
        chk("R5 wait state", 32'(tgt_n_i), (k >= ready) ? 0 : 1);
        chk("R5 medium ready", 32'(tgt_n_m), 32'(tgt_n_i));
        chk("R4 data drive", 32'(ad_oe_i), 1);
        chk("R2 medium select data", 32'(sel_n_m), 0);
        if (!tgt_n_i) chk("R4 data word", ad_out_i, word_of(off + done));
        if (stall) chk("R6 hold", ad_out_i, held);
      end
      irdy = !last && (pat != 0) && ((k + pat) % 3 == 0);
      if (!irdy && done == nb - 1) last = 1;
      init_rdy_n = irdy; start_n = last; cmd_in = 4'h0; ad_in = 32'hDEAD_0000 + 32'(k);
      stall = (k > 0) && !tgt_n_i && irdy;
      held = ad_out_i;
      if ((k > 0) && !tgt_n_i && !irdy) begin done++; ready = k + 2 + lat; end
      @(negedge clk);
      k++;
    end
    chk("R8 release ctl_oe", 32'(ctl_oe_i), 1);
    chk("R8 release select", 32'(sel_n_i), 1);
    chk("R8 release ready", 32'(tgt_n_i), 1);
    chk("R8 release ad_oe", 32'(ad_oe_i), 0);
    chk("R8 medium release", 32'(sel_n_m), 1);
    start_n = 1'b1; init_rdy_n = 1'b1;
    @(negedge clk);
    chk("R8 released", 32'(ctl_oe_i), 0);
    chk("R8 medium released", 32'(ctl_oe_m), 0);
  endtask

  task automatic run_miss(logic [31:0] a, logic [3:0] c);
    @(negedge clk);
    start_n = 1'b0; ad_in = a; cmd_in = c; init_rdy_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 miss ctl_oe", 32'(ctl_oe_i | ctl_oe_m), 0);
      chk("R9 miss ad_oe", 32'(ad_oe_i | ad_oe_m), 0);
      chk("R9 miss request", 32'(rd_req_i | rd_req_m), 0);
      if (k > 0) chk("R10 no redecode", 32'(ctl_oe_i), 0);
      ad_in = BASE; cmd_in = 4'h6; init_rdy_n = 1'b0;
    end
    start_n = 1'b1; init_rdy_n = 1'b1;
    @(negedge clk);
    chk("R9 miss after", 32'(ctl_oe_i | rd_req_i), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctl_oe", 32'(ctl_oe_i), 0);
    chk("R1 reset select", 32'(sel_n_i), 1);
    chk("R1 reset ready", 32'(tgt_n_i), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle ad_oe", 32'(ad_oe_i), 0);
    for (int oi = 0; oi < 3; oi++)
      for (int lat = 0; lat < 4; lat++)
        for (int nb = 1; nb < 5; nb++)
          for (int pat = 0; pat < 4; pat++)
            run_read(oi == 0 ? 0 : (oi == 1 ? 17 : 62), nb, lat, pat);
    run_miss(BASE - 32'd4, 4'h6);
    run_miss(BASE + 32'd256, 4'h6);
    run_miss(BASE + 32'd8, 4'h7);
    run_miss(BASE + 32'd8, 4'h2);
    run_miss(BASE + 32'd9, 4'h6);
    run_read(5, 2, 1, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule